// File: doc/BRIEF.md
# Timer Event Flag Register Unit

This block keeps the sticky event flags of an eight-channel capture/compare timer and its counter-overflow flag. Each channel raises a one-cycle event pulse when a capture or compare happens, and the counter raises a pulse when it wraps. Each pulse sets a flag that stays set until software clears it. The block drives a per-channel interrupt request and an overflow interrupt request, each gated by an enable bit.

Software reaches the flags over a single-cycle synchronous byte port. It clears them by writing ones to the flag registers, but only while the timer or the pulse accumulator is enabled. When fast-clear mode is on, any read or write of a channel's two-byte data window clears that channel's flag as a side effect. The block also stages a new prescale selection. It holds an update-pending output high until the external prescaler reports a point where all its stages are zero. At that point the prescaler latches the staged value.

Top module: `tmr_flag_unit`

## Requirements
- R1: After reset all channel flags, the overflow flag, the read data, the interrupt outputs, the staged prescale value and the update-pending output are 0.
- R2: A 1 on `ch_evt_i[n]` sets channel flag n one clock later. The flag stays set with no further events until it is cleared.
- R3: A write to offset 0x0E clears every channel flag whose data bit is 1, while `tmr_en_i` or `acc_en_i` is 1. Flags whose data bit is 0 keep their value.
- R4: While both `tmr_en_i` and `acc_en_i` are 0, writes to offsets 0x0E and 0x0F change no flag.
- R5: While `fast_clr_i` is 1, a read or a write of offset 0x10+2n or 0x11+2n clears channel flag n, whatever the enables are. While `fast_clr_i` is 0, such accesses clear nothing.
- R6: Offset 0x0F reads the overflow flag in bit 7, and bits 6:0 always read 0. `ovf_evt_i` sets the flag. Writing 1 to bit 7, with an enable active, clears it. Writing to bits 6:0 has no effect.
- R7: If a set event and a clear request for the same flag fall in the same cycle, the flag ends up set.
- R8: `ch_irq_o[n]` is channel flag n AND `ch_ie_i[n]`. `ovf_irq_o` is the overflow flag AND `ovf_ie_i`.
- R9: The read data is registered. It is updated one clock after `rd_i` and holds the flag values from before any clear caused by that same access.
- R10: A write to offset 0x0D stores bits 2:0 as the staged prescale value on `psc_sel_o` and sets `psc_upd_o`. `psc_upd_o` stays high until the clock after `psc_zero_i` is 1. A write in the same cycle as `psc_zero_i` keeps it high. Offset 0x0D reads back the staged value in bits 2:0.
- R11: Reads of any offset other than 0x0D, 0x0E and 0x0F return 0, including the channel data window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| ch_evt_i | input | 8 | Per-channel capture/compare event pulses |
| ovf_evt_i | input | 1 | Counter overflow pulse |
| tmr_en_i | input | 1 | Timer enable |
| acc_en_i | input | 1 | Pulse accumulator enable |
| fast_clr_i | input | 1 | Fast-clear mode |
| ch_ie_i | input | 8 | Per-channel interrupt enables |
| ovf_ie_i | input | 1 | Overflow interrupt enable |
| ch_irq_o | output | 8 | Per-channel interrupt requests |
| ovf_irq_o | output | 1 | Overflow interrupt request |
| psc_zero_i | input | 1 | Prescaler stages all at zero |
| psc_sel_o | output | 3 | Staged prescale selection |
| psc_upd_o | output | 1 | Staged prescale selection pending |

## Verification
Assertions check several rules on every cycle. An event always leaves its flag set on the next cycle, even against a clear. A flag changes only through a set or a clear request. The disabled enables block every write-clear request. Bits 6:0 of the overflow register read as zero. The prescale pending bit rises after a write and holds until a zero point. The bench scenarios are needed for the rest: the exact bit masks of write-one clearing, the mapping of each two-byte data window to its channel, the read data holding pre-clear values on a combined read and clear access, and the interrupt gating.

// File: rtl/tmr_flag_pkg.sv
package tmr_flag_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned OFS_PSC = 'h0D;
  localparam int unsigned OFS_CHF = 'h0E;
  localparam int unsigned OFS_OVF = 'h0F;
  localparam int unsigned CH_BASE = 'h10;
  localparam int unsigned CH_SPAN = 2;
endpackage

// File: rtl/tmr_flag_decode.sv
module tmr_flag_decode
  import tmr_flag_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tmr_en_i,
  input  logic              acc_en_i,
  input  logic              fast_clr_i,
  output logic [N_CH-1:0]   ch_clr_o,
  output logic              ovf_clr_o,
  output logic              psc_wr_o
);
  logic clr_ok;
  logic hit_chf;
  logic any_acc;

  assign clr_ok  = tmr_en_i | acc_en_i;
  assign hit_chf = addr_i == ADDR_W'(OFS_CHF);
  assign any_acc = rd_i | wr_i;

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    logic wc_hit;
    logic fc_hit;
    // both bytes of the channel window count
    assign wc_hit = wr_i & clr_ok & hit_chf & wdata_i[n];
    assign fc_hit = fast_clr_i & any_acc &
                    ({addr_i[ADDR_W-1:1], 1'b0} == ADDR_W'(CH_BASE + CH_SPAN * n));
    assign ch_clr_o[n] = wc_hit | fc_hit;
  end

  assign ovf_clr_o = wr_i & clr_ok & (addr_i == ADDR_W'(OFS_OVF)) & wdata_i[DATA_W-1];
  assign psc_wr_o  = wr_i & (addr_i == ADDR_W'(OFS_PSC));

  // R4
  wc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmr_en_i && !acc_en_i && !fast_clr_i) |-> (ch_clr_o == '0 && !ovf_clr_o));
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  for (genvar n = 0; n < W; n++) begin : g_bit
    logic flag_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q <= 1'b0;
      else if (set_i[n])  flag_q <= 1'b1;
      else if (clr_i[n])  flag_q <= 1'b0;
    end

    assign flag_o[n] = flag_q;

    // R7
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[n] |=> flag_o[n]);
    // R2
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[n] && !clr_i[n]) |=> flag_o[n]);
    // R2
    no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!flag_o[n] && !set_i[n]) |=> !flag_o[n]);
  end
endmodule

// File: rtl/tmr_psc_stage.sv
module tmr_psc_stage #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PSC_W-1:0] wdata_i,
  input  logic             zero_i,
  output logic [PSC_W-1:0] sel_o,
  output logic             upd_o
);
  logic [PSC_W-1:0] sel_q;
  logic             upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      upd_q <= 1'b0;
    end else if (wr_i) begin
      sel_q <= wdata_i;
      upd_q <= 1'b1;
    end else if (zero_i) begin
      upd_q <= 1'b0;
    end
  end

  assign sel_o = sel_q;
  assign upd_o = upd_q;

  // R10
  psc_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (upd_o && sel_o == $past(wdata_i)));
  // R10
  psc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && !zero_i) |=> upd_o);
endmodule

// File: rtl/tmr_flag_unit.sv
module tmr_flag_unit
  import tmr_flag_pkg::*;
#(
  parameter int unsigned N_CH   = 8,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned PSC_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_CH-1:0]   ch_evt_i,
  input  logic              ovf_evt_i,
  input  logic              tmr_en_i,
  input  logic              acc_en_i,
  input  logic              fast_clr_i,
  input  logic [N_CH-1:0]   ch_ie_i,
  input  logic              ovf_ie_i,
  output logic [N_CH-1:0]   ch_irq_o,
  output logic              ovf_irq_o,
  input  logic              psc_zero_i,
  output logic [PSC_W-1:0]  psc_sel_o,
  output logic              psc_upd_o
);
  logic [N_CH-1:0]   ch_clr;
  logic [N_CH-1:0]   ch_flag;
  logic              ovf_clr;
  logic              ovf_flag;
  logic              psc_wr;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  tmr_flag_decode #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .tmr_en_i   (tmr_en_i),
    .acc_en_i   (acc_en_i),
    .fast_clr_i (fast_clr_i),
    .ch_clr_o   (ch_clr),
    .ovf_clr_o  (ovf_clr),
    .psc_wr_o   (psc_wr)
  );

  tmr_flag_bank #(.W(N_CH)) u_ch_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ch_evt_i),
    .clr_i  (ch_clr),
    .flag_o (ch_flag)
  );

  tmr_flag_bank #(.W(1)) u_ovf_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_evt_i),
    .clr_i  (ovf_clr),
    .flag_o (ovf_flag)
  );

  tmr_psc_stage #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (psc_wr),
    .wdata_i (wdata_i[PSC_W-1:0]),
    .zero_i  (psc_zero_i),
    .sel_o   (psc_sel_o),
    .upd_o   (psc_upd_o)
  );

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(OFS_CHF))      rd_mux = DATA_W'(ch_flag);
    else if (addr_i == ADDR_W'(OFS_OVF)) rd_mux = {ovf_flag, {(DATA_W-1){1'b0}}};
    else if (addr_i == ADDR_W'(OFS_PSC)) rd_mux = DATA_W'(psc_sel_o);
  end

  // captured before the same-edge clear lands in the flag banks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign ch_irq_o  = ch_flag & ch_ie_i;
  assign ovf_irq_o = ovf_flag & ovf_ie_i;

  // R6
  ovf_pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_W'(OFS_OVF)) |=> (rdata_o[DATA_W-2:0] == '0));
  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/tmr_flag_unit_test.sv
module tmr_flag_unit_test;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_PSC = 5'h0D, A_CHF = 5'h0E, A_OVF = 5'h0F;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] ch_evt_i = '0;
  logic       ovf_evt_i = 1'b0;
  logic       tmr_en_i = 1'b0, acc_en_i = 1'b0, fast_clr_i = 1'b0;
  logic [7:0] ch_ie_i = '0;
  logic       ovf_ie_i = 1'b0;
  logic [7:0] ch_irq_o;
  logic       ovf_irq_o;
  logic       psc_zero_i = 1'b0;
  logic [2:0] psc_sel_o;
  logic       psc_upd_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  tmr_flag_unit uut (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o,
    .ch_evt_i, .ovf_evt_i, .tmr_en_i, .acc_en_i, .fast_clr_i,
    .ch_ie_i, .ovf_ie_i, .ch_irq_o, .ovf_irq_o,
    .psc_zero_i, .psc_sel_o, .psc_upd_o
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; d = rdata_o;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [7:0] v);
    @(negedge clk_i); addr_i = a; wdata_i = v; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic pulse_ch(input logic [7:0] m);
    @(negedge clk_i); ch_evt_i = m;
    @(negedge clk_i); ch_evt_i = '0;
  endtask

  task automatic pulse_ovf();
    @(negedge clk_i); ovf_evt_i = 1'b1;
    @(negedge clk_i); ovf_evt_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdata", rdata_o, 8'h00);
    chk("R1 ch_irq", ch_irq_o, 8'h00);
    chk("R1 psc", {4'b0, psc_upd_o, psc_sel_o}, 8'h00);
    bus_rd(A_CHF, d); chk("R1 chf", d, 8'h00);
    bus_rd(A_OVF, d); chk("R1 ovf", d, 8'h00);
  endtask

  task automatic t_set_irq();
    logic [7:0] d;
    pulse_ch(8'h05);
    bus_rd(A_CHF, d); chk("R2 set", d, 8'h05);
    repeat (4) @(negedge clk_i);
    bus_rd(A_CHF, d); chk("R2 sticky", d, 8'h05);
    ch_ie_i = 8'h01; #1; chk("R8 irq masked", ch_irq_o, 8'h01);
    ch_ie_i = 8'hFF; #1; chk("R8 irq all", ch_irq_o, 8'h05);
    ch_ie_i = 8'h00;
  endtask

  task automatic t_write_clear();
    logic [7:0] d;
    tmr_en_i = 1'b1;
    bus_wr(A_CHF, 8'h04);
    bus_rd(A_CHF, d); chk("R3 clr one", d, 8'h01);
    bus_wr(A_CHF, 8'h00);
    bus_rd(A_CHF, d); chk("R3 zero write", d, 8'h01);
    tmr_en_i = 1'b0;
    bus_wr(A_CHF, 8'hFF);
    bus_rd(A_CHF, d); chk("R4 gated", d, 8'h01);
    acc_en_i = 1'b1;
    bus_wr(A_CHF, 8'h01);
    bus_rd(A_CHF, d); chk("R3 acc enable", d, 8'h00);
    acc_en_i = 1'b0;
  endtask

  task automatic t_overflow();
    logic [7:0] d;
    pulse_ovf();
    bus_rd(A_OVF, d); chk("R6 set", d, 8'h80);
    ovf_ie_i = 1'b1; #1; chk("R8 ovf irq", {7'b0, ovf_irq_o}, 8'h01);
    tmr_en_i = 1'b1;
    bus_wr(A_OVF, 8'h7F);
    bus_rd(A_OVF, d); chk("R6 low bits", d, 8'h80);
    tmr_en_i = 1'b0;
    bus_wr(A_OVF, 8'h80);
    bus_rd(A_OVF, d); chk("R4 ovf gated", d, 8'h80);
    tmr_en_i = 1'b1;
    bus_wr(A_OVF, 8'h80);
    bus_rd(A_OVF, d); chk("R6 clear", d, 8'h00);
    chk("R8 ovf irq off", {7'b0, ovf_irq_o}, 8'h00);
    tmr_en_i = 1'b0; ovf_ie_i = 1'b0;
  endtask

  task automatic t_fast_clear();
    logic [7:0] d;
    pulse_ch(8'hFF);
    bus_rd(5'h14, d);
    bus_wr(5'h1F, 8'h00);
    bus_rd(A_CHF, d); chk("R5 mode off", d, 8'hFF);
    fast_clr_i = 1'b1;
    bus_rd(5'h14, d); chk("R11 data window", d, 8'h00);
    bus_rd(A_CHF, d); chk("R5 read ch2", d, 8'hFB);
    bus_wr(5'h1F, 8'h00);
    bus_rd(A_CHF, d); chk("R5 write ch7", d, 8'h7B);
    bus_rd(5'h11, d);
    bus_rd(A_CHF, d); chk("R5 high byte ch0", d, 8'h7A);
    fast_clr_i = 1'b0;
  endtask

  task automatic t_read_before_clear();
    logic [7:0] d;
    tmr_en_i = 1'b1;
    @(negedge clk_i); addr_i = A_CHF; wdata_i = 8'h02; rd_i = 1'b1; wr_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; wr_i = 1'b0;
    chk("R9 pre-clear", rdata_o, 8'h7A);
    bus_rd(A_CHF, d); chk("R9 post-clear", d, 8'h78);
    tmr_en_i = 1'b0;
  endtask

  task automatic t_collision();
    logic [7:0] d;
    tmr_en_i = 1'b1;
    @(negedge clk_i); ch_evt_i = 8'h01; ovf_evt_i = 1'b1;
    addr_i = A_CHF; wdata_i = 8'h09; wr_i = 1'b1;
    @(negedge clk_i); ch_evt_i = '0; ovf_evt_i = 1'b0; wr_i = 1'b0;
    bus_rd(A_CHF, d); chk("R7 ch set wins", d, 8'h71);
    @(negedge clk_i); ovf_evt_i = 1'b1; addr_i = A_OVF; wdata_i = 8'h80; wr_i = 1'b1;
    @(negedge clk_i); ovf_evt_i = 1'b0; wr_i = 1'b0;
    bus_rd(A_OVF, d); chk("R7 ovf set wins", d, 8'h80);
    tmr_en_i = 1'b0;
  endtask

  task automatic t_prescale();
    logic [7:0] d;
    bus_wr(A_PSC, 8'hFD);
    chk("R10 staged", {4'b0, psc_upd_o, psc_sel_o}, 8'h0D);
    bus_rd(A_PSC, d); chk("R10 readback", d, 8'h05);
    repeat (3) @(negedge clk_i);
    chk("R10 hold", {7'b0, psc_upd_o}, 8'h01);
    @(negedge clk_i); psc_zero_i = 1'b1;
    @(negedge clk_i); psc_zero_i = 1'b0;
    chk("R10 drop", {4'b0, psc_upd_o, psc_sel_o}, 8'h05);
    @(negedge clk_i); addr_i = A_PSC; wdata_i = 8'h02; wr_i = 1'b1; psc_zero_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0; psc_zero_i = 1'b0;
    chk("R10 write beats zero", {4'b0, psc_upd_o, psc_sel_o}, 8'h0A);
    bus_rd(5'h03, d); chk("R11 unmapped", d, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_set_irq();
    t_write_clear();
    t_overflow();
    t_fast_clear();
    t_read_before_clear();
    t_collision();
    t_prescale();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule